// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the register file through which a host processor hands commands to an embedded power-management microcontroller and picks up the results. The host sees a plain 32-bit register port with separate read and write strobes and a byte address. It can load two 32-bit pointer words and up to four 32-bit input words. It then writes a command word, which starts a transaction. The host follows progress through a status word and reads the results from an output buffer.

On the controller side, the block emits a one-cycle start strobe. Alongside the strobe it drives the decoded command fields, the pointers and the whole input buffer. The controller ends the transaction with a one-cycle completion strobe. With that strobe it supplies an error flag, an 8-bit error code and four output words. If the issued command asked for it, completion raises a sticky interrupt flag and drives the interrupt line. The host clears the flag by writing a 1 to it.

The host keeps one command in flight at a time. A second command written while the first is still busy is dropped. The command-id field of the status word lets the host match a result to the request that produced it.

Top module: `pmu_mailbox`

## Requirements
- R1: After synchronous reset, every register reads zero, `irq` is low and `ctl_start` is low.
- R2: A host write to byte address 0x00 while busy is clear issues a command. One cycle after that write edge, `ctl_start` is high for exactly one cycle. `ctl_opcode` then shows write bits 7:0, `ctl_sub` shows bits 15:12 and `ctl_len` shows bits 23:16. Bit 8 is the interrupt enable. Reading 0x00 returns the stored word with bits 31:24 and 11:9 forced to zero.
- R3: A write to 0x00 while busy is set is ignored. It produces no start strobe and leaves the stored command unchanged.
- R4: A completion strobe while busy clears busy. It stores the error flag in status bit 1 and the error code in status bits 23:16. It captures the four output words, which the host reads at 0x90, 0x94, 0x98 and 0x9C.
- R5: Status bit 0 is busy. Status bits 7:4 hold the sub-command of the last issued command. Bits 3, 15:8 and 31:24 read zero.
- R6: A completion for a command issued with bit 8 set raises status bit 2 and `irq`. A completion for a command issued with bit 8 clear leaves both unchanged. `irq` is status bit 2 ANDed with the enable bit of the last issued command.
- R7: A host write to status (0x04) with bit 2 set clears the interrupt flag. Bit 2 clear leaves the flag unchanged. No write changes the busy, error, code or command-id fields. If a completion and a clear land in the same cycle, the completion wins.
- R8: Writes to 0x80, 0x84, 0x88 and 0x8C load input words 0 to 3. Word i drives `ctl_in_data` bits 32i+31:32i. Reads in that range return zero.
- R9: The source pointer (0x08) and destination pointer (0x0C) can be read and written at any time, and drive `ctl_src_ptr` and `ctl_dst_ptr`.
- R10: Host writes to the output buffer (0x90 to 0x9F) have no effect.
- R11: A completion strobe that arrives while busy is clear changes no state.
- R12: `hst_rdata` carries the addressed word one cycle after the edge that samples `hst_re`, and zero otherwise. Unmapped addresses read zero.
- R13: Issuing a command clears the error bit and the error code. The codes follow the usual meanings: 0 none, 1 not supported, 2 not serviced, 3 unable to service, 4 invalid, 5 failed, 6 security rejection, 7 unsigned image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host write strobe |
| hst_re | input | 1 | Host read strobe |
| hst_addr | input | 8 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |
| ctl_start | output | 1 | One-cycle command strobe to the controller |
| ctl_opcode | output | 8 | Opcode of the issued command |
| ctl_sub | output | 4 | Sub-command of the issued command |
| ctl_len | output | 8 | Input byte count of the issued command |
| ctl_src_ptr | output | 32 | Source pointer register |
| ctl_dst_ptr | output | 32 | Destination pointer register |
| ctl_in_data | output | 128 | Input buffer, word 0 in the low bits |
| ctl_done | input | 1 | Completion strobe from the controller |
| ctl_err | input | 1 | Completion failed |
| ctl_err_code | input | 8 | Completion error code |
| ctl_out_data | input | 128 | Output words, word 0 in the low bits |
| irq | output | 1 | Completion interrupt |

## Verification
Every result has a known latency. A command write shows up on `ctl_start` and the field outputs one cycle after its edge. A completion or a status write shows up in the status word and on `irq` one cycle after its edge. A read appears on `hst_rdata` one cycle after the edge that samples `hst_re`. The bench drives inputs and samples outputs on the falling edge. Its behavioural model is updated at each rising edge with these same latencies and is compared with the outputs at every falling edge. The directed reads use the same one-cycle rule: the word a read returns is taken on the falling edge that follows the sampling edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // byte offsets of the host-visible registers
  localparam int OFF_CMD  = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_SRC  = 'h08;
  localparam int OFF_DST  = 'h0C;
  localparam int OFF_IN   = 'h80;
  localparam int OFF_OUT  = 'h90;

  // status flag used by the write-one-to-clear path
  localparam int STAT_IRQ_BIT = 2;

  typedef enum logic [7:0] {
    ERR_NONE        = 8'd0,
    ERR_UNSUPPORTED = 8'd1,
    ERR_UNSERVICED  = 8'd2,
    ERR_CANNOT      = 8'd3,
    ERR_INVALID     = 8'd4,
    ERR_FAILED      = 8'd5,
    ERR_SECURITY    = 8'd6,
    ERR_UNSIGNED    = 8'd7
  } mbox_err_e;

  typedef struct packed {
    logic [7:0] len;
    logic [3:0] sub;
    logic       ien;
    logic [7:0] opcode;
  } cmd_fields_t;
endpackage

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr_i,
  input  cmd_fields_t       cmd_i,
  input  logic              clr_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [CODE_W-1:0] code_i,
  output cmd_fields_t       cmd_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [CODE_W-1:0] code_o,
  output logic              flag_o,
  output logic              start_o,
  output logic              accept_o,
  output logic              irq_o
);
  cmd_fields_t       cmd_q;
  logic              busy_q, err_q, flag_q, start_q;
  logic [CODE_W-1:0] code_q;
  logic              issue, accept;

  assign issue  = cmd_wr_i & ~busy_q;
  assign accept = done_i & busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= '0;
      flag_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= issue;
      if (issue) begin
        cmd_q  <= cmd_i;
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (accept) begin
        busy_q <= 1'b0;
        err_q  <= err_i;
        code_q <= code_i;
      end
      // completion has priority over a host clear in the same cycle
      if (accept && cmd_q.ien) flag_q <= 1'b1;
      else if (clr_i)          flag_q <= 1'b0;
    end
  end

  assign cmd_o    = cmd_q;
  assign busy_o   = busy_q;
  assign err_o    = err_q;
  assign code_o   = code_q;
  assign flag_o   = flag_q;
  assign start_o  = start_q;
  assign accept_o = accept;
  assign irq_o    = flag_q & cmd_q.ien;

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    start_q |-> busy_q);
  assert_no_issue_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cmd_wr_i) |=> (!start_q && $stable(cmd_q)));
  assert_done_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && done_i) |=> (!busy_q && err_q == $past(err_i) && code_q == $past(code_i)));
  assert_flag_src_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(done_i && busy_q));
  assert_idle_done_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && done_i && !cmd_wr_i && !clr_i) |=>
      (!busy_q && $stable(err_q) && $stable(code_q) && $stable(flag_q)));
endmodule

// File: rtl/mbox_wbuf.sv
module mbox_wbuf #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDXW-1:0]     wr_idx,
  input  logic [DW-1:0]       wr_data,
  output logic [WORDS*DW-1:0] data_o
);
  logic [WORDS-1:0][DW-1:0] words_q;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                  words_q[i] <= '0;
      else if (wr_en && wr_idx == IDXW'(i))     words_q[i] <= wr_data;
    end
  end

  assign data_o = words_q;

  assert_wbuf_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(words_q));
endmodule

// File: rtl/mbox_rbuf.sv
module mbox_rbuf #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_i,
  input  logic [WORDS*DW-1:0] cap_data_i,
  input  logic [IDXW-1:0]     rd_idx,
  output logic [DW-1:0]       rd_word
);
  logic [WORDS-1:0][DW-1:0] words_q;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)        words_q[i] <= '0;
      else if (cap_i) words_q[i] <= cap_data_i[i*DW +: DW];
    end
  end

  assign rd_word = words_q[rd_idx];

  // only a completion may change the output words; host writes never reach here
  assert_rbuf_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(words_q));
endmodule

// File: rtl/pmu_mailbox.sv
module pmu_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DW        = 32,
  parameter int BUF_WORDS = 4,
  parameter int CODE_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hst_we,
  input  logic                    hst_re,
  input  logic [ADDR_W-1:0]       hst_addr,
  input  logic [DW-1:0]           hst_wdata,
  output logic [DW-1:0]           hst_rdata,
  output logic                    ctl_start,
  output logic [7:0]              ctl_opcode,
  output logic [3:0]              ctl_sub,
  output logic [7:0]              ctl_len,
  output logic [DW-1:0]           ctl_src_ptr,
  output logic [DW-1:0]           ctl_dst_ptr,
  output logic [BUF_WORDS*DW-1:0] ctl_in_data,
  input  logic                    ctl_done,
  input  logic                    ctl_err,
  input  logic [CODE_W-1:0]       ctl_err_code,
  input  logic [BUF_WORDS*DW-1:0] ctl_out_data,
  output logic                    irq
);
  localparam int IDXW      = $clog2(BUF_WORDS);
  localparam int BUF_BYTES = BUF_WORDS * (DW / 8);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFF_SRC);
  localparam logic [ADDR_W-1:0] A_DST  = ADDR_W'(OFF_DST);

  // address decode
  logic in_hit, out_hit;
  logic [IDXW-1:0] buf_idx;
  assign in_hit  = (int'(hst_addr) >= OFF_IN)  && (int'(hst_addr) < OFF_IN + BUF_BYTES);
  assign out_hit = (int'(hst_addr) >= OFF_OUT) && (int'(hst_addr) < OFF_OUT + BUF_BYTES);
  assign buf_idx = hst_addr[IDXW+1:2];

  // command fields taken from the write word
  cmd_fields_t cmd_wr_fields, cmd_cur;
  assign cmd_wr_fields.opcode = hst_wdata[7:0];
  assign cmd_wr_fields.ien    = hst_wdata[8];
  assign cmd_wr_fields.sub    = hst_wdata[15:12];
  assign cmd_wr_fields.len    = hst_wdata[23:16];

  logic              busy, err, flag, accept;
  logic [CODE_W-1:0] code;

  mbox_seq #(.CODE_W(CODE_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr_i (hst_we && hst_addr == A_CMD),
    .cmd_i    (cmd_wr_fields),
    .clr_i    (hst_we && hst_addr == A_STAT && hst_wdata[STAT_IRQ_BIT]),
    .done_i   (ctl_done),
    .err_i    (ctl_err),
    .code_i   (ctl_err_code),
    .cmd_o    (cmd_cur),
    .busy_o   (busy),
    .err_o    (err),
    .code_o   (code),
    .flag_o   (flag),
    .start_o  (ctl_start),
    .accept_o (accept),
    .irq_o    (irq)
  );

  mbox_wbuf #(.WORDS(BUF_WORDS), .DW(DW)) u_wbuf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (hst_we && in_hit),
    .wr_idx  (buf_idx),
    .wr_data (hst_wdata),
    .data_o  (ctl_in_data)
  );

  logic [DW-1:0] out_word;
  mbox_rbuf #(.WORDS(BUF_WORDS), .DW(DW)) u_rbuf (
    .clk        (clk),
    .rst        (rst),
    .cap_i      (accept),
    .cap_data_i (ctl_out_data),
    .rd_idx     (buf_idx),
    .rd_word    (out_word)
  );

  // pointer registers
  logic [DW-1:0] src_q, dst_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (hst_we) begin
      if (hst_addr == A_SRC) src_q <= hst_wdata;
      if (hst_addr == A_DST) dst_q <= hst_wdata;
    end
  end

  // read mux and registered read data
  logic [31:0] stat_word, cmd_word;
  logic [DW-1:0] rd_val;
  assign stat_word = {8'd0, 8'(code), 8'd0, cmd_cur.sub, 1'b0, flag, err, busy};
  assign cmd_word  = {8'd0, cmd_cur.len, cmd_cur.sub, 3'd0, cmd_cur.ien, cmd_cur.opcode};

  always_comb begin
    rd_val = '0;
    if      (hst_addr == A_CMD)  rd_val = DW'(cmd_word);
    else if (hst_addr == A_STAT) rd_val = DW'(stat_word);
    else if (hst_addr == A_SRC)  rd_val = src_q;
    else if (hst_addr == A_DST)  rd_val = dst_q;
    else if (out_hit)            rd_val = out_word;
  end

  always_ff @(posedge clk) begin
    if (rst) hst_rdata <= '0;
    else     hst_rdata <= hst_re ? rd_val : '0;
  end

  assign ctl_opcode  = cmd_cur.opcode;
  assign ctl_sub     = cmd_cur.sub;
  assign ctl_len     = cmd_cur.len;
  assign ctl_src_ptr = src_q;
  assign ctl_dst_ptr = dst_q;

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (hst_we && hst_addr == A_STAT && hst_wdata[STAT_IRQ_BIT] && !ctl_done) |=> !irq);
  assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !hst_re |=> hst_rdata == '0);
endmodule

// File: tb/pmu_mailbox_tb.sv
`timescale 1ns/1ps
module pmu_mailbox_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hst_we = 0, hst_re = 0;
  logic [7:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0;
  logic [31:0] hst_rdata;
  logic ctl_start;
  logic [7:0] ctl_opcode, ctl_len;
  logic [3:0] ctl_sub;
  logic [31:0] ctl_src_ptr, ctl_dst_ptr;
  logic [127:0] ctl_in_data;
  logic ctl_done = 0, ctl_err = 0;
  logic [7:0] ctl_err_code = 0;
  logic [127:0] ctl_out_data = 0;
  logic irq;

  always #2 clk = ~clk;

  pmu_mailbox u_dut (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ctl_start(ctl_start),
    .ctl_opcode(ctl_opcode), .ctl_sub(ctl_sub), .ctl_len(ctl_len),
    .ctl_src_ptr(ctl_src_ptr), .ctl_dst_ptr(ctl_dst_ptr), .ctl_in_data(ctl_in_data),
    .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code),
    .ctl_out_data(ctl_out_data), .irq(irq)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic m_busy, m_err, m_flag, m_start;
  logic [7:0] m_code;
  logic [31:0] m_cmd, m_src, m_dst, m_rdata;
  logic [31:0] m_in [4];
  logic [31:0] m_out [4];
  bit seen = 0;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h00) return m_cmd;
    if (a == 8'h04) return {8'd0, m_code, 8'd0, m_cmd[15:12], 1'b0, m_flag, m_err, m_busy};
    if (a == 8'h08) return m_src;
    if (a == 8'h0C) return m_dst;
    if (a >= 8'h90 && a < 8'hA0) return m_out[a[3:2]];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_err = 0; m_flag = 0; m_start = 0; m_code = 0;
      m_cmd = 0; m_src = 0; m_dst = 0; m_rdata = 0;
      for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; end
    end else begin
      logic [31:0] rv;
      logic iss, acc;
      rv  = model_read(hst_addr);
      iss = hst_we && hst_addr == 8'h00 && !m_busy;
      acc = ctl_done && m_busy;
      m_rdata = hst_re ? rv : 32'd0;
      m_start = iss;
      if (iss) begin
        m_cmd = hst_wdata & 32'h00FF_F1FF; m_busy = 1; m_err = 0; m_code = 0;
      end else if (acc) begin
        m_busy = 0; m_err = ctl_err; m_code = ctl_err_code;
        for (int i = 0; i < 4; i++) m_out[i] = ctl_out_data[32*i +: 32];
      end
      if (acc && m_cmd[8]) m_flag = 1;
      else if (hst_we && hst_addr == 8'h04 && hst_wdata[2]) m_flag = 0;
      if (hst_we && hst_addr == 8'h08) m_src = hst_wdata;
      if (hst_we && hst_addr == 8'h0C) m_dst = hst_wdata;
      if (hst_we && hst_addr >= 8'h80 && hst_addr < 8'h90) m_in[hst_addr[3:2]] = hst_wdata;
    end
    seen = 1;
  end

  always @(negedge clk) begin
    if (seen && !rst && !finished) begin
      logic [127:0] in_exp;
      for (int i = 0; i < 4; i++) in_exp[32*i +: 32] = m_in[i];
      check("R2 ctl_start", ctl_start, m_start);
      check("R2 fields", {ctl_len, ctl_sub, ctl_opcode}, {m_cmd[23:16], m_cmd[15:12], m_cmd[7:0]});
      check("R6 irq", irq, m_flag & m_cmd[8]);
      check("R8 ctl_in_data", ctl_in_data, in_exp);
      check("R9 pointers", {ctl_src_ptr, ctl_dst_ptr}, {m_src, m_dst});
      check("R12 hst_rdata", hst_rdata, m_rdata);
    end
  end

  logic last_start;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); hst_we = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_we = 0; last_start = ctl_start;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); hst_re = 1; hst_addr = a;
    @(negedge clk); hst_re = 0; d = hst_rdata;
  endtask

  task automatic complete(input logic e, input logic [7:0] c, input logic [127:0] o);
    @(negedge clk); ctl_done = 1; ctl_err = e; ctl_err_code = c; ctl_out_data = o;
    @(negedge clk); ctl_done = 0; ctl_err = 0; ctl_err_code = 0; ctl_out_data = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(8'h04, d); check("R1 status after reset", d, 32'h0);
    rd(8'h00, d); check("R1 command after reset", d, 32'h0);
    check("R1 irq after reset", irq, 1'b0);
    // R9 pointers
    wr(8'h08, 32'h1234_5678);
    wr(8'h0C, 32'hCAFE_0001);
    rd(8'h08, d); check("R9 src readback", d, 32'h1234_5678);
    check("R9 dst port", ctl_dst_ptr, 32'hCAFE_0001);
    // R8 input buffer
    wr(8'h80, 32'h1111_0000); wr(8'h84, 32'h2222_0000);
    wr(8'h88, 32'h3333_0000); wr(8'h8C, 32'h4444_0000);
    rd(8'h84, d); check("R8 input read zero", d, 32'h0);
    check("R8 word2 on port", ctl_in_data[95:64], 32'h3333_0000);
    // R2 issue with interrupt enable, sub 3, len 16
    wr(8'h00, 32'hFF10_3FEB);
    check("R2 start seen", last_start, 1'b1);
    check("R2 decoded fields", {ctl_opcode, ctl_sub, ctl_len}, {8'hEB, 4'h3, 8'h10});
    rd(8'h00, d); check("R2 reserved bits masked", d, 32'h0010_31EB);
    rd(8'h04, d); check("R5 busy and command id", d, 32'h0000_0031);
    // R3 ignored while busy
    wr(8'h00, 32'h0000_50AA);
    check("R3 no start while busy", last_start, 1'b0);
    rd(8'h00, d); check("R3 command kept", d, 32'h0010_31EB);
    // R4/R6 completion with interrupt
    complete(1'b0, 8'h00, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
    rd(8'h04, d); check("R6 flag set, R4 busy clear", d, 32'h0000_0034);
    check("R6 irq high", irq, 1'b1);
    rd(8'h94, d); check("R4 output word1", d, 32'hA1);
    // R10 output buffer writes ignored
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h90, d); check("R10 output word0 kept", d, 32'hA0);
    // R7 write-one-to-clear
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, d); check("R7 zero write keeps flag", d, 32'h0000_0034);
    wr(8'h04, 32'hFFFF_FFFB);
    rd(8'h04, d); check("R7 other bits write keeps all", d, 32'h0000_0034);
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, d); check("R7 flag cleared", d, 32'h0000_0030);
    check("R7 irq low", irq, 1'b0);
    // R11 idle completion dropped
    complete(1'b1, 8'h05, {4{32'h5555_5555}});
    rd(8'h04, d); check("R11 status unchanged", d, 32'h0000_0030);
    rd(8'h9C, d); check("R11 output unchanged", d, 32'hA3);
    // R6 no interrupt enable, error completion
    wr(8'h00, 32'h0000_20EC);
    rd(8'h04, d); check("R5 command id 2", d, 32'h0000_0021);
    complete(1'b1, 8'h07, {32'hB3, 32'hB2, 32'hB1, 32'hB0});
    rd(8'h04, d); check("R4 error code and bit", d, 32'h0007_0022);
    check("R6 irq stays low", irq, 1'b0);
    // R13 new command clears error
    wr(8'h00, 32'h0000_10ED);
    rd(8'h04, d); check("R13 error cleared on issue", d, 32'h0000_0011);
    complete(1'b0, 8'h00, {32'hC3, 32'hC2, 32'hC1, 32'hC0});
    rd(8'h98, d); check("R4 output word2", d, 32'hC2);
    // R12 unmapped read
    rd(8'h40, d); check("R12 unmapped reads zero", d, 32'h0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule